// File: doc/BRIEF.md
# Round-Robin Shared Permutation Arbiter

This block lets several sampler clients share one 1600-bit permutation core. Each client issues a request by pulsing a valid for a single cycle, with its state on its own slice of the request bus in that same cycle. Clients never check whether the core is free. The arbiter therefore keeps one pending slot per client, made of a flag and a state register. It grants pending work to the core in round-robin order, one request at a time.

When the core finishes, the result is returned only to the client that owns the request. The response valid is per client, and the result data is driven to all clients in parallel. A client that is not the owner never sees its valid rise, so a client that latches data whenever its valid is high cannot corrupt its own state. Clients are always ready to take a result, and each client keeps at most one request outstanding.

Top module: `perm_share_arb`

## Requirements
- R1: The reset is synchronous and active high. In the cycle after reset, `core_req_vld` and every bit of `cli_rsp_vld` are low. Client requests that were pending when reset arrived are discarded and never reach the core. The grant pointer returns to client 0.
- R2: A request that arrives while the core is busy, or while `core_ready` is low, is held in the arbiter. It is later sent to the core with its state bit-for-bit unchanged.
- R3: At most one request is in flight. After a `core_req_vld` pulse, no new pulse appears until the core has answered with `core_rsp_vld`.
- R4: A request is sent to the core only if `core_ready` was high in the cycle of the grant. While `core_ready` stays low, `core_req_vld` stays low.
- R5: Grants rotate in round-robin order. The search starts at the client after the last one granted, wrapping from the highest index to client 0, and starts at client 0 after reset. Two examples for three clients with the pointer at 2: request mask 3'b101 (bit i = client i) is served 2 then 0, and mask 3'b111 is served 2, 0, 1.
- R6: One cycle after `core_rsp_vld`, `cli_rsp_vld` has exactly one bit set, the owner's bit. In that same cycle, `cli_rsp_state` carries the core result. In every other cycle `cli_rsp_vld` is zero.
- R7: Suppose a request pulse arrives while the core is idle and no other request is pending. Then `core_req_vld` is high in the very next cycle, carrying that pulse's state. The request does not wait in the pending slot.
- R8: `core_req_vld` is high for exactly one cycle per granted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cli_req_vld | input | N_CLIENTS | Single-cycle request pulse, one bit per client |
| cli_req_state | input | N_CLIENTS*STATE_W | Request states; client i uses bits [i*STATE_W +: STATE_W] |
| core_req_vld | output | 1 | Request pulse toward the permutation core |
| core_req_state | output | STATE_W | State handed to the core |
| core_ready | input | 1 | Core can accept a request |
| core_rsp_vld | input | 1 | Core result valid (one cycle) |
| core_rsp_state | input | STATE_W | Core result |
| cli_rsp_vld | output | N_CLIENTS | Result valid, only the owning client's bit |
| cli_rsp_state | output | STATE_W | Result data, shared by all clients |

## Verification
The bound checker watches the following on every cycle:
- `core_req_vld` stays a one-cycle pulse.
- A new request never overlaps one still in flight.
- No request is issued without `core_ready`.
- Each response goes to one client only, and only to a client that actually asked.

The bench's scenarios cover what needs a history of several transactions:
- The exact rotation order under various request masks.
- Requests parked through a busy or stalled core and later issued with their data intact.
- The same-cycle bypass timing.
- Pending requests disappearing across a mid-run reset.

// File: rtl/perm_arb_pkg.sv
`timescale 1ns/1ps
package perm_arb_pkg;
  localparam int unsigned DEF_CLIENTS = 3;
  localparam int unsigned DEF_WIDTH   = 1600;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/perm_req_slot.sv
`timescale 1ns/1ps
// One pending-request slot per client. A pulse that is granted in its own
// cycle bypasses the slot; otherwise the state is parked until granted.
module perm_req_slot #(
  parameter int unsigned W = 1600
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_vld,
  input  logic [W-1:0] req_state,
  input  logic         take,
  output logic         eff_vld,
  output logic [W-1:0] eff_state
);
  logic         pend_q;
  logic [W-1:0] slot_q;

  assign eff_vld   = pend_q | req_vld;
  assign eff_state = pend_q ? slot_q : req_state;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (take) begin
      pend_q <= 1'b0;
    end else if (req_vld) begin
      pend_q <= 1'b1;
    end
  end

  // data path without reset so it maps onto plain fabric registers
  always_ff @(posedge clk) begin
    if (!pend_q && req_vld) begin
      slot_q <= req_state;
    end
  end
endmodule

// File: rtl/perm_rr_pick.sv
`timescale 1ns/1ps
// Round-robin picker: first requesting client at or after ptr, wrapping.
module perm_rr_pick #(
  parameter int unsigned N  = 3,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);
  int unsigned cand;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    cand    = 0;
    // walk from the far end so the nearest candidate is written last
    for (int k = N - 1; k >= 0; k--) begin
      cand = int'(ptr) + k;
      if (cand >= N) cand = cand - N;
      if (req[cand]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/perm_share_arb.sv
`timescale 1ns/1ps
module perm_share_arb
  import perm_arb_pkg::*;
#(
  parameter int unsigned N_CLIENTS = DEF_CLIENTS,
  parameter int unsigned STATE_W   = DEF_WIDTH
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_CLIENTS-1:0]           cli_req_vld,
  input  logic [N_CLIENTS*STATE_W-1:0]   cli_req_state,
  output logic                           core_req_vld,
  output logic [STATE_W-1:0]             core_req_state,
  input  logic                           core_ready,
  input  logic                           core_rsp_vld,
  input  logic [STATE_W-1:0]             core_rsp_state,
  output logic [N_CLIENTS-1:0]           cli_rsp_vld,
  output logic [STATE_W-1:0]             cli_rsp_state
);
  localparam int unsigned IW = idx_bits(N_CLIENTS);
  localparam logic [IW-1:0] LAST_IDX = IW'(N_CLIENTS - 1);
  localparam logic [N_CLIENTS-1:0] ONE = {{(N_CLIENTS-1){1'b0}}, 1'b1};

  logic [N_CLIENTS-1:0] eff_vld;
  logic [STATE_W-1:0]   eff_state [N_CLIENTS];
  logic [N_CLIENTS-1:0] take;

  logic                 busy_q;
  logic [IW-1:0]        owner_q;
  logic [IW-1:0]        ptr_q;
  logic                 gnt_vld;
  logic [IW-1:0]        gnt_idx;
  logic                 issue;

  assign issue = gnt_vld && core_ready && !busy_q;

  genvar gi;
  generate
    for (gi = 0; gi < N_CLIENTS; gi++) begin : g_slot
      assign take[gi] = issue && (gnt_idx == IW'(gi));
      perm_req_slot #(.W(STATE_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .req_vld   (cli_req_vld[gi]),
        .req_state (cli_req_state[gi*STATE_W +: STATE_W]),
        .take      (take[gi]),
        .eff_vld   (eff_vld[gi]),
        .eff_state (eff_state[gi])
      );
    end
  endgenerate

  perm_rr_pick #(.N(N_CLIENTS), .IW(IW)) u_pick (
    .req     (eff_vld),
    .ptr     (ptr_q),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      owner_q      <= '0;
      ptr_q        <= '0;
      core_req_vld <= 1'b0;
      cli_rsp_vld  <= '0;
    end else begin
      core_req_vld <= issue;
      if (issue) begin
        busy_q  <= 1'b1;
        owner_q <= gnt_idx;
        ptr_q   <= (gnt_idx == LAST_IDX) ? '0 : gnt_idx + 1'b1;
      end else if (core_rsp_vld) begin
        busy_q  <= 1'b0;
      end
      cli_rsp_vld <= (core_rsp_vld && busy_q) ? (ONE << owner_q) : '0;
    end
  end

  // wide data registers, no reset
  always_ff @(posedge clk) begin
    if (issue) begin
      core_req_state <= eff_state[gnt_idx];
    end
    if (core_rsp_vld) begin
      cli_rsp_state <= core_rsp_state;
    end
  end
endmodule

// File: rtl/perm_share_arb_chk.sv
`timescale 1ns/1ps
module perm_share_arb_chk #(
  parameter int unsigned N_CLIENTS = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_CLIENTS-1:0] cli_req_vld,
  input logic                 core_req_vld,
  input logic                 core_ready,
  input logic                 core_rsp_vld,
  input logic [N_CLIENTS-1:0] cli_rsp_vld
);
  logic outst_q;
  logic rst_d;

  always_ff @(posedge clk) begin
    if (rst)               outst_q <= 1'b0;
    else if (core_req_vld) outst_q <= 1'b1;
    else if (core_rsp_vld) outst_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      p_reset_clear_r1: assert (core_req_vld == 1'b0 && cli_rsp_vld == '0);
    end
  end

  p_one_inflight_r3: assert property (@(posedge clk) disable iff (rst)
    core_req_vld |-> !outst_q);

  p_issue_ready_r4: assert property (@(posedge clk) disable iff (rst)
    core_req_vld |-> $past(core_ready));

  p_rsp_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cli_rsp_vld));

  p_rsp_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (core_rsp_vld && outst_q) |=> ($countones(cli_rsp_vld) == 1));

  p_req_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    core_req_vld |=> !core_req_vld);

  genvar ci;
  generate
    for (ci = 0; ci < N_CLIENTS; ci++) begin : g_owed
      logic owed_q;
      always_ff @(posedge clk) begin
        if (rst)                  owed_q <= 1'b0;
        else if (cli_req_vld[ci]) owed_q <= 1'b1;
        else if (cli_rsp_vld[ci]) owed_q <= 1'b0;
      end
      p_rsp_owner_r6: assert property (@(posedge clk) disable iff (rst)
        cli_rsp_vld[ci] |-> owed_q);
    end
  endgenerate
endmodule

bind perm_share_arb perm_share_arb_chk #(.N_CLIENTS(N_CLIENTS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cli_req_vld  (cli_req_vld),
  .core_req_vld (core_req_vld),
  .core_ready   (core_ready),
  .core_rsp_vld (core_rsp_vld),
  .cli_rsp_vld  (cli_rsp_vld)
);

// File: tb/perm_share_arb_tb_top.sv
`timescale 1ns/1ps
module perm_share_arb_tb_top;
  localparam int N   = 3;
  localparam int W   = 1600;
  localparam int LAT = 4;
  localparam int NV  = 8;
  // [10:8] request mask, [5:4] first, [3:2] second, [1:0] third grant
  localparam logic [11:0] VEC [NV] = '{
    12'h304, 12'h520, 12'h718, 12'h420,
    12'h618, 12'h100, 12'h520, 12'h210
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N-1:0]     cli_req_vld = '0;
  logic [N*W-1:0]   cli_req_state = '0;
  logic             core_req_vld;
  logic [W-1:0]     core_req_state;
  logic             core_ready;
  logic             core_rsp_vld = 1'b0;
  logic [W-1:0]     core_rsp_state = '0;
  logic [N-1:0]     cli_rsp_vld;
  logic [W-1:0]     cli_rsp_state;

  always #5 clk = ~clk;

  perm_share_arb #(.N_CLIENTS(N), .STATE_W(W)) dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mk_state(input int id, input int tag);
    logic [W-1:0] s;
    for (int b = 0; b < W / 16; b++) s[b*16 +: 16] = {8'(tag), 8'(id)};
    return s;
  endfunction

  // core stub: fixed latency, result is the bitwise inverse
  logic         run_q = 1'b0;
  logic         stall = 1'b0;
  int           cnt_q = 0;
  logic [W-1:0] st_q = '0;
  assign core_ready = !run_q && !stall;

  always @(negedge clk) begin
    if (rst) begin
      run_q = 1'b0;
      core_rsp_vld = 1'b0;
    end else begin
      core_rsp_vld = 1'b0;
      if (run_q) begin
        cnt_q = cnt_q - 1;
        if (cnt_q == 0) begin
          run_q = 1'b0;
          core_rsp_vld = 1'b1;
          core_rsp_state = ~st_q;
        end
      end else if (core_req_vld) begin
        run_q = 1'b1;
        cnt_q = LAT;
        st_q = core_req_state;
      end
    end
  end

  // monitor: logs issued requests, checks routing of every response
  int           iss_n = 0;
  int           rsp_n = 0;
  int           iss_id [64];
  logic [W-1:0] iss_st [64];
  logic         prev_req = 1'b0;
  logic         mon_out = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      iss_n = 0; rsp_n = 0; prev_req = 1'b0; mon_out = 1'b0;
    end else begin
      if (core_req_vld) begin
        check(!prev_req, "R8 req pulse width", 64'(prev_req), 64'd0);
        check(!mon_out, "R3 one in flight", 64'(mon_out), 64'd0);
        iss_id[iss_n] = int'(core_req_state[7:0]);
        iss_st[iss_n] = core_req_state;
        iss_n++;
        mon_out = 1'b1;
      end
      if (cli_rsp_vld != '0) begin
        check(cli_rsp_vld == (N'(1) << iss_id[rsp_n]), "R6 rsp owner",
              64'(cli_rsp_vld), 64'(N'(1) << iss_id[rsp_n]));
        check(cli_rsp_state == ~iss_st[rsp_n], "R6 rsp data",
              cli_rsp_state[63:0], ~iss_st[rsp_n][63:0]);
        rsp_n++;
        mon_out = 1'b0;
      end
      prev_req = core_req_vld;
    end
  end

  task automatic pulse(input logic [N-1:0] mask, input int tag);
    for (int i = 0; i < N; i++) cli_req_state[i*W +: W] = mk_state(i, tag);
    cli_req_vld = mask;
    @(negedge clk);
    cli_req_vld = '0;
  endtask

  task automatic wait_rsp(input int target);
    while (rsp_n < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int s;
    int tag;
    logic [N-1:0] m;
    tag = 1;
    @(negedge clk);
    do_reset();
    // R1: reset state
    check(core_req_vld == 1'b0, "R1 core_req_vld after reset", 64'(core_req_vld), 64'd0);
    check(cli_rsp_vld == '0, "R1 cli_rsp_vld after reset", 64'(cli_rsp_vld), 64'd0);

    // R5 table: rotation order for several masks
    for (int v = 0; v < NV; v++) begin
      m = VEC[v][10:8];
      s = iss_n;
      pulse(m, tag);
      tag++;
      wait_rsp(s + $countones(m));
      check(iss_n == s + $countones(m), "R5 grant count", 64'(iss_n - s), 64'($countones(m)));
      for (int k = 0; k < $countones(m); k++) begin
        check(iss_id[s+k] == int'(VEC[v][5-2*k -: 2]), "R5 grant order",
              64'(iss_id[s+k]), 64'(VEC[v][5-2*k -: 2]));
      end
    end

    // R7: bypass from an idle core
    s = iss_n;
    for (int i = 0; i < N; i++) cli_req_state[i*W +: W] = mk_state(i, 8'h77);
    cli_req_vld = 3'b100;
    @(negedge clk);
    cli_req_vld = '0;
    check(core_req_vld == 1'b1, "R7 bypass timing", 64'(core_req_vld), 64'd1);
    check(core_req_state == mk_state(2, 8'h77), "R7 bypass data",
          core_req_state[63:0], mk_state(2, 8'h77)[63:0]);
    wait_rsp(s + 1);

    // R2: request parked while core busy
    s = iss_n;
    pulse(3'b001, 8'h41);
    @(negedge clk);
    pulse(3'b100, 8'h42);
    wait_rsp(s + 2);
    check(iss_id[s+1] == 2, "R2 held request issued", 64'(iss_id[s+1]), 64'd2);
    check(iss_st[s+1] == mk_state(2, 8'h42), "R2 held state intact",
          iss_st[s+1][63:0], mk_state(2, 8'h42)[63:0]);

    // R4: no issue while core_ready is low
    s = iss_n;
    stall = 1'b1;
    pulse(3'b010, 8'h55);
    repeat (8) @(negedge clk);
    check(iss_n == s, "R4 no issue without ready", 64'(iss_n - s), 64'd0);
    stall = 1'b0;
    wait_rsp(s + 1);
    check(iss_st[s] == mk_state(1, 8'h55), "R2 stalled state intact",
          iss_st[s][63:0], mk_state(1, 8'h55)[63:0]);

    // R1: reset mid-run drops pending requests and rewinds pointer
    pulse(3'b111, 8'h60);
    @(negedge clk);
    do_reset();
    repeat (10) @(negedge clk);
    check(iss_n == 0, "R1 pending discarded", 64'(iss_n), 64'd0);
    check(rsp_n == 0 && cli_rsp_vld == '0, "R1 no response after reset", 64'(rsp_n), 64'd0);
    pulse(3'b101, 8'h61);
    wait_rsp(2);
    check(iss_id[0] == 0 && iss_id[1] == 2, "R1 pointer back to client 0",
          64'(iss_id[0]), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule